// File: doc/BRIEF.md
# Lockable Double-Buffered PWM Timer

A single-channel pulse-width generator driven by a small register port. Software programs a cycle length (period), a high-phase length (duty) and a control word that enables counting and selects the output level for each phase. The output is left-aligned: every period opens with its duty phase and ends with its idle phase. All lengths are counted in input clock cycles.

Period, duty and the two level bits are double-buffered. Register writes land in a software-visible shadow copy. The waveform uses a separate working copy, which is refreshed only when one period ends and the next begins. A lock bit in the control word blocks that refresh. Software sets the lock, rewrites any of the three settings, then clears the lock. The whole new set then takes over together at the next period start, so the output never shows a waveform that mixes old and new settings.

Top module: `pwm_lockable`

## Requirements
- R1: After an asynchronous active-low reset, every register reads 0, the counter is 0, and `pwm_out` is 0.
- R2: Register offsets are 0x0 = counter (read-only; writes to it are ignored), 0x4 = period, 0x8 = duty and 0xC = control. Reads of period and duty return the last value written. Control keeps only bits 0, 1, 3, 4, 5, 6 and 8, and reads 0 in every other bit.
- R3: The channel runs only while control bit 0 (enable) and bit 1 (continuous) are both 1. Otherwise the counter is held at 0 and `pwm_out` equals control bit 4. While stopped with the lock clear, the working copy follows the shadow copy.
- R4: While running, the counter steps 0, 1, …, P−1 and wraps back to 0, where P is the working period. A working period of 0 or 1 holds the counter at 0.
- R5: While running, `pwm_out` shows the working duty level (control bit 3 at load time) while counter < working duty, and the working idle level (control bit 4) otherwise.
- R6: If working duty ≥ working period, the output stays at the duty level for the whole period. A working duty of 0 keeps it at the idle level.
- R7: With the lock clear, a write to period, duty or the level bits during a running period leaves the waveform unchanged until the counter wraps. The new values apply from the next period on.
- R8: While control bit 6 (lock) is 1, writes still update the shadow copy, but the working copy is frozen. The counter keeps wrapping on the old period.
- R9: After the lock is cleared, the shadow period, duty and both level bits become active together at the next wrap, never in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Pulse output |

## Verification
A corrupted working copy shows up at `pwm_out` within one period: the edge between duty and idle phases moves, or the phase levels are swapped. A counter that wraps at the wrong value shows up on a counter read in the very next cycle. A working copy loaded too early (in mid-period or under lock) changes the output before the counter wraps. That is visible within the period that is running. The bench therefore compares the counter readback and the output on every cycle against a cycle-level model.

// File: rtl/pwm_lk_pkg.sv
package pwm_lk_pkg;
    localparam logic [3:0] OFS_COUNT  = 4'h0;
    localparam logic [3:0] OFS_PERIOD = 4'h4;
    localparam logic [3:0] OFS_DUTY   = 4'h8;
    localparam logic [3:0] OFS_CTRL   = 4'hC;

    localparam int CTRL_W     = 9;
    localparam int B_ENABLE   = 0;
    localparam int B_CONT     = 1;
    localparam int B_DUTY_LVL = 3;
    localparam int B_IDLE_LVL = 4;
    localparam int B_LOCK     = 6;
    localparam logic [CTRL_W-1:0] CTRL_KEEP = 9'h17B;

    typedef struct packed {
        logic duty_lvl;
        logic idle_lvl;
    } levels_t;
endpackage

// File: rtl/pwm_lk_regs.sv
module pwm_lk_regs
    import pwm_lk_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     count,
    output logic [DW-1:0]     bus_rdata,
    output logic [DW-1:0]     sh_period,
    output logic [DW-1:0]     sh_duty,
    output levels_t           sh_levels,
    output logic              run,
    output logic              lock
);
    typedef struct packed {
        logic [DW-1:0]     period;
        logic [DW-1:0]     duty;
        logic [CTRL_W-1:0] ctrl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            unique case (bus_addr)
                OFS_PERIOD: r_d.period = bus_wdata;
                OFS_DUTY:   r_d.duty   = bus_wdata;
                OFS_CTRL:   r_d.ctrl   = bus_wdata[CTRL_W-1:0] & CTRL_KEEP;
                default:    r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_COUNT:  bus_rdata = count;
            OFS_PERIOD: bus_rdata = r_q.period;
            OFS_DUTY:   bus_rdata = r_q.duty;
            OFS_CTRL:   bus_rdata = {{(DW-CTRL_W){1'b0}}, r_q.ctrl};
            default:    bus_rdata = '0;
        endcase
    end

    assign sh_period          = r_q.period;
    assign sh_duty            = r_q.duty;
    assign sh_levels.duty_lvl = r_q.ctrl[B_DUTY_LVL];
    assign sh_levels.idle_lvl = r_q.ctrl[B_IDLE_LVL];
    assign run                = r_q.ctrl[B_ENABLE] & r_q.ctrl[B_CONT];
    assign lock               = r_q.ctrl[B_LOCK];

    // R2
    period_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_PERIOD) |=> (sh_period == $past(bus_wdata)));
    // R2
    ctrl_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) |-> (bus_rdata[DW-1:CTRL_W] == '0 && bus_rdata[2] == 1'b0 && bus_rdata[7] == 1'b0));
endmodule

// File: rtl/pwm_lk_core.sv
module pwm_lk_core
    import pwm_lk_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          lock,
    input  logic [DW-1:0] sh_period,
    input  logic [DW-1:0] sh_duty,
    input  levels_t       sh_levels,
    output logic [DW-1:0] count,
    output logic          pwm_out
);
    localparam int CW = DW + 1;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] period;
        logic [DW-1:0] duty;
        levels_t       lvl;
    } core_t;

    core_t c_d, c_q;
    logic  wrap;

    assign wrap = ({1'b0, c_q.cnt} + CW'(1)) >= {1'b0, c_q.period};

    always_comb begin
        c_d = c_q;
        if (!run || wrap) begin
            c_d.cnt = '0;
            if (!lock) begin
                c_d.period = sh_period;
                c_d.duty   = sh_duty;
                c_d.lvl    = sh_levels;
            end
        end else begin
            c_d.cnt = c_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count = c_q.cnt;

    always_comb begin
        if (!run)                   pwm_out = sh_levels.idle_lvl;
        else if (c_q.cnt < c_q.duty) pwm_out = c_q.lvl.duty_lvl;
        else                        pwm_out = c_q.lvl.idle_lvl;
    end

    // R3
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0));
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) || (count < c_q.period));
    // R8
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(c_q.period) && $stable(c_q.duty) && $stable(c_q.lvl)));
    // R7
    mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(c_q.period) && $stable(c_q.duty) && $stable(c_q.lvl)));
endmodule

// File: rtl/pwm_lockable.sv
module pwm_lockable
    import pwm_lk_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          pwm_out
);
    logic [DW-1:0] count, sh_period, sh_duty;
    levels_t       sh_levels;
    logic          run, lock;

    pwm_lk_regs #(.DW(DW)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .count(count), .bus_rdata(bus_rdata),
        .sh_period(sh_period), .sh_duty(sh_duty), .sh_levels(sh_levels),
        .run(run), .lock(lock)
    );

    pwm_lk_core #(.DW(DW)) i_core (
        .clk(clk), .rst_n(rst_n), .run(run), .lock(lock),
        .sh_period(sh_period), .sh_duty(sh_duty), .sh_levels(sh_levels),
        .count(count), .pwm_out(pwm_out)
    );

    // R1
    reset_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwm_out == 1'b0));
endmodule

// File: tb/test_pwm_lockable.sv
module test_pwm_lockable;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  b_addr = 4'h0;
    logic        b_wr = 1'b0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic        pout;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_lockable i_pwm_lockable (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr),
        .bus_wdata(b_wdata), .bus_rdata(rdata), .pwm_out(pout)
    );

    // reference model, built from the requirements
    logic [31:0] m_per, m_dut, m_cnt, m_ap, m_ad;
    logic [8:0]  m_ctrl;
    logic        m_adl, m_ail;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_per = 0; m_dut = 0; m_cnt = 0; m_ap = 0; m_ad = 0;
            m_ctrl = 0; m_adl = 0; m_ail = 0;
        end else begin
            logic run, lk;
            run = m_ctrl[0] & m_ctrl[1];
            lk  = m_ctrl[6];
            if (!run || ({1'b0, m_cnt} + 33'd1 >= {1'b0, m_ap})) begin
                m_cnt = 0;
                if (!lk) begin
                    m_ap = m_per; m_ad = m_dut; m_adl = m_ctrl[3]; m_ail = m_ctrl[4];
                end
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (b_wr) begin
                case (b_addr)
                    4'h4: m_per = b_wdata;
                    4'h8: m_dut = b_wdata;
                    4'hC: m_ctrl = b_wdata[8:0] & 9'h17B;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic exp_out();
        if (!(m_ctrl[0] & m_ctrl[1])) return m_ctrl[4];
        return (m_cnt < m_ad) ? m_adl : m_ail;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h0: return m_cnt;
            4'h4: return m_per;
            4'h8: return m_dut;
            4'hC: return {23'd0, m_ctrl};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string auto_tag();
        if (!(m_ctrl[0] & m_ctrl[1])) return "R3";
        if (m_ctrl[6]) return "R8";
        if (m_ad == 0 || m_ad >= m_ap) return "R6";
        return "R5";
    endfunction

    task automatic do_checks(input string tag);
        string t_out, t_rd;
        logic  eo;
        logic [31:0] er;
        t_out = (tag == "") ? auto_tag() : tag;
        t_rd  = (tag != "") ? tag : ((b_addr == 4'h0) ? "R4" : "R2");
        eo = exp_out();
        er = exp_rd(b_addr);
        checks++;
        if (pout !== eo) begin
            errors++;
            $display("FAIL %s: pwm_out=%0b expected %0b (cnt=%0d)", t_out, pout, eo, m_cnt);
        end
        checks++;
        if (rdata !== er) begin
            errors++;
            $display("FAIL %s: rdata[%0h]=%0h expected %0h", t_rd, b_addr, rdata, er);
        end
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        do_checks(tag);
        b_wr = 1'b0;
        b_addr = 4'(($urandom % 4) * 4);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        b_wr = 1'b1; b_addr = a; b_wdata = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0001));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state on every register
        for (int i = 0; i < 4; i++) begin
            b_addr = 4'(i * 4);
            @(negedge clk);
            checks++;
            if (rdata !== 32'd0 || pout !== 1'b0) begin
                errors++;
                $display("FAIL R1: rdata=%0h out=%0b expected 0 0", rdata, pout);
            end
        end
        // R7: change period mid-period without lock
        tick("R1"); wr(4'h4, 10);
        tick("R5"); wr(4'h8, 5);
        tick("R5"); wr(4'hC, 32'h0B);
        repeat (25) tick("R5");
        while (m_cnt != 3) tick("R5");
        wr(4'h4, 4);
        repeat (20) tick("R7");
        // R8 / R9: lock, new period, duty, inverted levels, then unlock
        wr(4'hC, 32'h4B);
        tick("R8"); wr(4'h4, 6);
        tick("R8"); wr(4'h8, 2);
        tick("R8"); wr(4'hC, 32'h53);
        repeat (15) tick("R8");
        wr(4'hC, 32'h13);
        repeat (20) tick("R9");
        // R6: duty beyond period, then zero duty
        wr(4'h8, 9);
        repeat (15) tick("R6");
        wr(4'h8, 0);
        repeat (15) tick("R6");
        // R4: tiny periods
        wr(4'h4, 1);
        repeat (8) tick("R4");
        wr(4'h4, 0);
        repeat (8) tick("R4");
        // R3: only one of the two run bits
        wr(4'hC, 32'h11);
        repeat (6) tick("R3");
        wr(4'hC, 32'h02);
        repeat (6) tick("R3");
        // R2: write to counter offset ignored, unused control bits dropped
        wr(4'h0, 32'hFFFF_FFFF);
        tick("R2"); wr(4'hC, 32'hFFFF_FE84);
        tick("R2"); b_addr = 4'hC;
        @(negedge clk);
        checks++;
        if (rdata !== 32'h0000_0000) begin
            errors++;
            $display("FAIL R2: ctrl=%0h expected 0", rdata);
        end
        // random mix
        for (int n = 0; n < 4000; n++) begin
            tick("");
            if ($urandom % 6 == 0) begin
                logic [31:0] v;
                case ($urandom % 4)
                    0: wr(4'h4, $urandom % 11);
                    1: wr(4'h8, $urandom % 13);
                    2: begin
                        v = $urandom;
                        if ($urandom % 4 != 0) v[1:0] = 2'b11;
                        if ($urandom % 2 == 0) v[6] = 1'b0;
                        wr(4'hC, v);
                    end
                    default: wr(4'h0, $urandom);
                endcase
            end
        end
        tick("");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule